// File: doc/BRIEF.md
# Full-Duplex SPI Master with Variable Transfer Length

This block is an SPI master that sends between 1 and 32 bits on MOSI and captures MISO on every clock of the same transfer. Serial clock idles low, MOSI changes while SCLK is low, and both sides sample on the rising edge. A command carries a 32-bit transmit word, which is MSB-justified so that a lone byte sits in bits 31..24, and a 6-bit bit count. The finished transfer returns the received bits right-justified. The first eight bits received are treated as the peripheral's status byte and are held in a separate register.

Two per-command options cover the common uses of one-directional traffic. A fill option replaces the transmit data with all ones while reading. A write-only option keeps clocking data out but stops capturing once the status byte is in. The SCLK half-period is a whole number of system clocks, set by the `HALF_DIV` parameter.

The command side works as valid/ready. `start` is the valid. `busy` low is the ready, and a command is taken only in a cycle with `start` high and `busy` low; a `start` raised while `busy` is high is dropped, not held. The result side has no back-pressure. `done` pulses for one cycle, and `rx_word` and `status` stay valid until the next command is accepted.

Top module: `spi_fd_master`

## Requirements
- R1: After reset, `sclk`, `mosi`, `busy`, `done` are 0, and `rx_word` and `status` are all zeros.
- R2: A command is accepted on a clock edge where `start` is 1 and `busy` is 0, and `busy` is 1 from the next cycle until the transfer ends.
- R3: A `bit_count` above 32 is treated as 32. The number of rising SCLK edges in a transfer equals the clamped count.
- R4: A `bit_count` of 0 gives no SCLK edge, keeps `busy` at 0, clears `rx_word`, and raises `done` in the cycle after acceptance.
- R5: MOSI carries `tx_word[31]` first, then `tx_word[30]` and so on, one bit per SCLK period. MOSI is set at the start of each low phase and does not change while SCLK is high.
- R6: Received bits shift in at bit 0 with a left shift, so the first bit ends up in bit N-1 of `rx_word` and bits at N and above are 0. `rx_word` is cleared when a command is accepted.
- R7: Each SCLK period is `HALF_DIV` system clocks low, then `HALF_DIV` high, with MISO sampled at the end of the high phase. `done` is high for exactly the cycle that follows the clock edge `2*HALF_DIV*N` edges after acceptance.
- R8: Whenever `busy` is 0, including the cycle of `done`, `sclk` and `mosi` are both 0.
- R9: With `read_only` set at acceptance, MOSI is 1 for every bit of the transfer, whatever `tx_word` holds.
- R10: `status` takes the first eight bits received, with the first bit in `status[7]`, once the eighth bit is sampled. A transfer shorter than 8 bits leaves `status` unchanged, and `status` never changes while `busy` is 0.
- R11: With `write_only` set at acceptance, only the first eight bits are captured. Later MISO values do not change `rx_word`, which then holds the status byte in bits 7..0.
- R12: A `start` raised while `busy` is 1 has no effect. The running transfer's MOSI bits, clock count and result are unchanged, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command valid |
| tx_word | input | 32 | Transmit data, MSB-justified |
| bit_count | input | 6 | Bits to transfer, clamped to 32 |
| read_only | input | 1 | Send all-ones filler instead of `tx_word` |
| write_only | input | 1 | Stop capturing after the first byte |
| busy | output | 1 | Transfer in progress; low means a command can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 32 | Received bits, LSB-justified |
| status | output | 8 | First received byte |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
For a clamped count N, `done` is due exactly `2*HALF_DIV*N` clock edges after the accepting edge, or on the next edge when N is 0. Each scoreboard entry stores that cycle number together with the expected `rx_word`, `status`, MOSI bit string and rising-edge count. The monitor samples on the falling system clock edge, so it reads the registered results only after they have settled. It compares every field at the exact `done` cycle. MOSI is logged on each rising SCLK edge, and the modelled peripheral updates MISO on each falling SCLK edge, which matches the sampling points the block relies on. Any `done` that arrives with an empty queue is reported as a failure, and this is how the ignored mid-transfer `start` is caught.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_fd_half_timer.sv
module spi_fd_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_fd_tx_shift.sv
module spi_fd_tx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  output logic              next_bit
);
  // Holds the bits that follow the one already on the line.
  logic [WORD_W-1:0] sh_q;

  assign next_bit = sh_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load)    sh_q <= {load_word[WORD_W-2:0], 1'b0};
    else if (advance) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_fd_rx_capture.sv
module spi_fd_rx_capture #(
  parameter int WORD_W = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              stop_after_status,
  input  logic              miso,
  output logic [WORD_W-1:0] rx_word,
  output logic [STAT_W-1:0] status
);
  localparam int NW = $clog2(STAT_W + 1);
  localparam logic [NW-1:0] FULL = NW'(STAT_W);
  localparam logic [NW-1:0] LAST = NW'(STAT_W - 1);

  logic [WORD_W-1:0] rx_q;
  logic [STAT_W-1:0] st_q;
  logic [NW-1:0]     got_q;
  logic              capture;

  assign capture = sample && !(stop_after_status && (got_q == FULL));
  assign rx_word = rx_q;
  assign status  = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      st_q  <= '0;
      got_q <= '0;
    end else if (clear) begin
      rx_q  <= '0;
      got_q <= '0;
    end else if (capture) begin
      rx_q <= {rx_q[WORD_W-2:0], miso};
      if (got_q != FULL) got_q <= got_q + 1'b1;
      if (got_q == LAST) st_q <= {rx_q[STAT_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_fd_master.sv
module spi_fd_master
  import spi_fd_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int STAT_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic              read_only,
  input  logic              write_only,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic [STAT_W-1:0] status,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(WORD_W);

  phase_t           ph_q;
  logic [CNT_W-1:0] left_q;
  logic             fill_q, wonly_q, sclk_q, mosi_q, done_q;
  logic [CNT_W-1:0] n_req;
  logic             accept, tick, run, tx_next, end_high;

  assign busy     = (ph_q != PH_IDLE);
  assign accept   = start && !busy;
  assign n_req    = (bit_count > MAX_BITS) ? MAX_BITS : bit_count;
  assign run      = busy;
  assign end_high = (ph_q == PH_HIGH) && tick;
  assign done     = done_q;
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;

  spi_fd_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_fd_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(tx_word),
    .advance(end_high), .next_bit(tx_next)
  );

  spi_fd_rx_capture #(.WORD_W(WORD_W), .STAT_W(STAT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(end_high),
    .stop_after_status(wonly_q), .miso(miso),
    .rx_word(rx_word), .status(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      left_q  <= '0;
      fill_q  <= 1'b0;
      wonly_q <= 1'b0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            fill_q  <= read_only;
            wonly_q <= write_only;
            if (n_req == '0) begin
              done_q <= 1'b1;
            end else begin
              ph_q   <= PH_LOW;
              left_q <= n_req;
              sclk_q <= 1'b0;
              mosi_q <= read_only ? 1'b1 : tx_word[WORD_W-1];
            end
          end
        end
        PH_LOW: begin
          if (tick) begin
            ph_q   <= PH_HIGH;
            sclk_q <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (left_q == CNT_W'(1)) begin
              ph_q   <= PH_IDLE;
              mosi_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              ph_q   <= PH_LOW;
              mosi_q <= fill_q ? 1'b1 : tx_next;
            end
            left_q <= left_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fd_master_chk.sv
module spi_fd_master_chk #(
  parameter int CNT_W  = 6,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  bit_count,
  input logic              busy,
  input logic              done,
  input logic [STAT_W-1:0] status,
  input logic              sclk,
  input logic              mosi
);
  // R8: lines rest low whenever no transfer runs
  assert_idle_lines_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));

  // R5: MOSI holds across the whole high phase
  assert_mosi_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> (mosi == $past(mosi)));

  // R4: zero count finishes on the next edge without becoming busy
  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bit_count == '0) |=> (done && !busy));

  // R2: a non-zero command makes the block busy
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bit_count != '0) |=> busy);

  // R10: status does not move between transfers
  assert_status_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(status));

  // R7: completion is only flagged with the block ready again
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_fd_master spi_fd_master_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
  .busy(busy), .done(done), .status(status), .sclk(sclk), .mosi(mosi)
);

// File: tb/tb_spi_fd_master.sv
module tb_spi_fd_master;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  bit_count = '0;
  logic        read_only = 1'b0, write_only = 1'b0;
  logic        busy, done, sclk, mosi, miso;
  logic [31:0] rx_word;
  logic [7:0]  status;

  int errors = 0, checks = 0;
  int cyc = 0, issued = 0, completed = 0, rises = 0;
  logic [31:0] slv = '0;
  logic [31:0] mosi_log = '0;
  logic [7:0]  st_model = '0;

  typedef struct {
    logic [31:0] rx;
    logic [7:0]  st;
    logic [31:0] mo;
    int          nr;
    int          due;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_fd_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .bit_count(bit_count), .read_only(read_only), .write_only(write_only),
    .busy(busy), .done(done), .rx_word(rx_word), .status(status),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // modelled peripheral: MISO moves after each falling SCLK edge
  assign miso = slv[31];
  always @(negedge sclk) slv = slv << 1;
  always @(posedge sclk) begin
    mosi_log = {mosi_log[30:0], mosi};
    rises++;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each completion with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12", "unexpected done", 64'(cyc), 64'(0));
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rx_word == it.rx, "R6 R11", "rx_word", 64'(rx_word), 64'(it.rx));
        check(status == it.st, "R10", "status", 64'(status), 64'(it.st));
        check(mosi_log == it.mo, "R5 R9", "mosi bits", 64'(mosi_log), 64'(it.mo));
        check(rises == it.nr, "R3", "sclk rises", 64'(rises), 64'(it.nr));
        check(cyc == it.due, "R7", "done cycle", 64'(cyc), 64'(it.due));
        check(!busy && !sclk && !mosi, "R8", "lines at done",
              64'({busy, sclk, mosi}), 64'(0));
      end
      completed++;
    end
  end

  task automatic xfer(input logic [31:0] tx, input logic [5:0] cnt, input bit rd,
                      input bit wr, input logic [31:0] peer, input bit poke);
    item_t it;
    int n;
    logic [63:0] ones;
    n = (cnt > 6'd32) ? 32 : int'(cnt);
    ones = (64'd1 << n) - 64'd1;
    if (n == 0) it.rx = '0;
    else if (wr && n > 8) it.rx = peer >> 24;
    else it.rx = peer >> (32 - n);
    if (n >= 8) st_model = peer[31:24];
    it.st = st_model;
    if (n == 0) it.mo = '0;
    else it.mo = rd ? ones[31:0] : (tx >> (32 - n));
    it.nr = n;
    @(negedge clk);
    slv = peer; mosi_log = '0; rises = 0;
    tx_word = tx; bit_count = cnt; read_only = rd; write_only = wr; start = 1'b1;
    it.due = cyc + 1 + 2 * H * n;
    sb.push_back(it);
    issued++;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; tx_word = ~tx; bit_count = 6'd3; read_only = ~rd;
      @(negedge clk);
      start = 1'b0;
    end
    wait (completed == issued);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 64'(cyc), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!sclk && !mosi && !busy && !done && rx_word == 0 && status == 0, "R1",
          "reset outputs", 64'({sclk, mosi, busy, done, status}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    xfer(32'hA500_0000, 6'd8,  1'b0, 1'b0, 32'h3C00_0000, 1'b0); // R10 status byte
    xfer(32'h1234_5678, 6'd32, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0); // R5 R6 full word
    xfer(32'hF000_0000, 6'd5,  1'b0, 1'b0, 32'h5000_0000, 1'b0); // R10 short keeps status
    xfer(32'h8765_4321, 6'd40, 1'b0, 1'b0, 32'h0F0F_1234, 1'b0); // R3 clamp
    xfer(32'hFFFF_FFFF, 6'd0,  1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0); // R4 zero count
    xfer(32'h0000_0000, 6'd16, 1'b1, 1'b0, 32'h9ABC_0000, 1'b0); // R9 filler
    xfer(32'h5A5A_5A5A, 6'd24, 1'b0, 1'b1, 32'h81FF_FF00, 1'b0); // R11 write-only
    xfer(32'hC000_0000, 6'd4,  1'b0, 1'b1, 32'hB000_0000, 1'b0); // R11 short
    xfer(32'h6600_0000, 6'd12, 1'b0, 1'b0, 32'h7E50_0000, 1'b1); // R12 ignored start
    xfer(32'h8000_0000, 6'd1,  1'b0, 1'b0, 32'h8000_0000, 1'b0); // R2 single bit
    xfer(32'hDEAD_BEEF, 6'd63, 1'b1, 1'b1, 32'h1111_2222, 1'b0); // R3 R9 R11 combined
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R2", "pending items", 64'(sb.size()), 64'(0));
    check(completed == issued, "R12", "done count", 64'(completed), 64'(issued));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule